// File: doc/BRIEF.md
# Vectored USB Interrupt Request Controller

This block gathers twenty-one USB event sources onto one CPU interrupt line. Five are device-wide events (setup data ready, start of frame, setup token seen, suspend, bus reset). Sixteen are bulk endpoint events, eight IN and eight OUT. Each source has a request latch and an enable bit. The interrupt line is the OR of every latch that is both pending and enabled.

The USB core drives the global events as one-cycle pulses. It drives each endpoint's busy flag as a level. An endpoint's latch is set on the cycle its busy flag falls, which is when its buffer has been handed back to the CPU. Software reads and writes six byte-wide registers through a simple port. The request registers are write-one-to-clear, and the enable registers are plain read/write.

A vector output gives four times the index of the highest-priority source that is pending and enabled. Dispatch software can add it straight into a jump table of four-byte entries.

Top module: `usb_irq_vectorizer`

## Requirements
- R1: After reset, all request latches and enable bits are 0, `irq` is 0 and `vec` is 0.
- R2: A 1 on bit k of `glob_evt` sets global request bit k. The bits are: 0 setup data ready, 1 start of frame, 2 setup token, 3 suspend, 4 bus reset. The new state is visible from the next clock edge.
- R3: A falling edge on `in_busy[k]` or `out_busy[k]` sets IN or OUT request bit k at the clock edge where the low level is first sampled. A rising or steady busy level sets nothing.
- R4: Writing to a request register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: Register addresses are 0 global request, 1 global enable, 2 IN request, 3 IN enable, 4 OUT request, 5 OUT enable. Global registers use data bits 4:0. `rd_data` returns the addressed register combinationally, and unused addresses read 0.
- R6: `irq` is 1 exactly when at least one source is both pending and enabled. A pending source that is disabled stays readable in its request register but does not raise `irq`.
- R7: Source indices are 0..4 for the global bits, 5..12 for IN0..IN7 and 13..20 for OUT0..OUT7. The lowest index among the pending, enabled sources wins, and `vec` equals 4 times that index, so its two LSBs are always 0.
- R8: When no source is pending and enabled, `vec` is 0. `vec` and `irq` follow a latch clear with no extra register delay.
- R9: When an event sets a request bit in the same cycle that software writes 1 to clear that bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data of addressed register |
| glob_evt | input | 5 | Global event pulses from the USB core |
| in_busy | input | 8 | IN endpoint busy levels |
| out_busy | input | 8 | OUT endpoint busy levels |
| irq | output | 1 | Interrupt request to the CPU |
| vec | output | 8 | Vector of highest-priority enabled pending source |

## Verification
Two functions can land on the same edge: an event setting a latch and a software write-one-to-clear aimed at that same bit. The bench drives a global event pulse and a clearing write on the same negative clock edge, so both are sampled together. It then reads back the request register, which must still hold the bit. It also fires a busy fall in the same cycle as a clear of that endpoint's bit and judges the result the same way. Beyond this collision, every source is swept alone and in every pair, with the expected vector computed as four times the smaller index.

// File: rtl/usb_irq_pkg.sv
// Package: shared counts, source index layout and register address codes
// for the vectored USB interrupt controller.
package usb_irq_pkg;
    localparam int NUM_GLOBAL = 5;
    localparam int ADDR_W     = 3;

    // Register address map seen by software.
    typedef enum logic [ADDR_W-1:0] {
        RA_GLB_REQ = 3'd0,
        RA_GLB_EN  = 3'd1,
        RA_IN_REQ  = 3'd2,
        RA_IN_EN   = 3'd3,
        RA_OUT_REQ = 3'd4,
        RA_OUT_EN  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/irq_latch_bank.sv
// Module: irq_latch_bank
// One group of request latches with enable bits.
// - Set inputs win over software clears arriving in the same cycle.
// - Request writes are write-one-to-clear; enable writes load the value.
// Assumes single-cycle write strobes and synchronous active-low reset.
module irq_latch_bank #(
    parameter int W      = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      set_i,
    input  logic              clr_we,
    input  logic              en_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [W-1:0]      req_o,
    output logic [W-1:0]      en_o
);
    logic [W-1:0] clr_mask;

    // Select the bits a clearing write targets.
    always_comb begin
        clr_mask = clr_we ? wdata[W-1:0] : '0;
    end

    // Request latches: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= '0;
        else        req_o <= (req_o & ~clr_mask) | set_i;
    end

    // Enable register: plain load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_o <= '0;
        else if (en_we) en_o <= wdata[W-1:0];
    end
endmodule

// File: rtl/busy_fall_detect.sv
// Module: busy_fall_detect
// Produces a one-cycle pulse when a busy level goes from 1 to 0.
// The history register takes the live level during reset, so a level
// that is already low when reset ends produces no pulse.
module busy_fall_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] busy_i,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] busy_q;

    // Remember the previous busy level.
    always_ff @(posedge clk) begin
        busy_q <= busy_i;
    end

    // Flag bits that were busy and now are not, gated by reset.
    always_comb begin
        fall_o = rst_n ? (busy_q & ~busy_i) : '0;
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Module: irq_prio_enc
// Fixed-priority encoder: the lowest index among active inputs wins.
// The vector output is four times the winning index and is 0 when
// nothing is active. Purely combinational.
module irq_prio_enc #(
    parameter int N     = 21,
    parameter int VEC_W = 8
) (
    input  logic [N-1:0]     act_i,
    output logic             any_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam int IDX_W = VEC_W - 2;

    logic [IDX_W-1:0] win_idx;

    // Scan downward so the lowest active index is the last one assigned.
    always_comb begin
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act_i[i]) win_idx = IDX_W'(i);
        end
    end

    // Form the interrupt line and the four-byte-spaced vector.
    always_comb begin
        any_o = |act_i;
        vec_o = {win_idx, 2'b00};
    end
endmodule

// File: rtl/usb_irq_vectorizer.sv
// Module: usb_irq_vectorizer (top)
// Merges five global USB events and sixteen bulk endpoint events into one
// interrupt line plus a jump-table vector. Assumes global events arrive as
// one-cycle pulses and endpoint busy flags as levels.
module usb_irq_vectorizer
    import usb_irq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int EP_COUNT = 8,
    parameter int VEC_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [NUM_GLOBAL-1:0] glob_evt,
    input  logic [EP_COUNT-1:0]   in_busy,
    input  logic [EP_COUNT-1:0]   out_busy,
    output logic                  irq,
    output logic [VEC_W-1:0]      vec
);
    localparam int NUM_SRC = NUM_GLOBAL + 2 * EP_COUNT;

    logic [NUM_GLOBAL-1:0] glb_req, glb_en;
    logic [EP_COUNT-1:0]   in_req, in_en, out_req, out_en;
    logic [EP_COUNT-1:0]   in_fall, out_fall;
    logic [NUM_SRC-1:0]    req_all, en_all, act_all;

    // Decode write strobes per register.
    logic we_glb_req, we_glb_en, we_in_req, we_in_en, we_out_req, we_out_en;
    always_comb begin
        we_glb_req = wr_en && (wr_addr == RA_GLB_REQ);
        we_glb_en  = wr_en && (wr_addr == RA_GLB_EN);
        we_in_req  = wr_en && (wr_addr == RA_IN_REQ);
        we_in_en   = wr_en && (wr_addr == RA_IN_EN);
        we_out_req = wr_en && (wr_addr == RA_OUT_REQ);
        we_out_en  = wr_en && (wr_addr == RA_OUT_EN);
    end

    busy_fall_detect #(.W(EP_COUNT)) u_in_fall (
        .clk(clk), .rst_n(rst_n), .busy_i(in_busy), .fall_o(in_fall)
    );
    busy_fall_detect #(.W(EP_COUNT)) u_out_fall (
        .clk(clk), .rst_n(rst_n), .busy_i(out_busy), .fall_o(out_fall)
    );

    irq_latch_bank #(.W(NUM_GLOBAL), .DATA_W(DATA_W)) u_glb (
        .clk(clk), .rst_n(rst_n), .set_i(glob_evt),
        .clr_we(we_glb_req), .en_we(we_glb_en), .wdata(wr_data),
        .req_o(glb_req), .en_o(glb_en)
    );
    irq_latch_bank #(.W(EP_COUNT), .DATA_W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n), .set_i(in_fall),
        .clr_we(we_in_req), .en_we(we_in_en), .wdata(wr_data),
        .req_o(in_req), .en_o(in_en)
    );
    irq_latch_bank #(.W(EP_COUNT), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .set_i(out_fall),
        .clr_we(we_out_req), .en_we(we_out_en), .wdata(wr_data),
        .req_o(out_req), .en_o(out_en)
    );

    // Concatenate sources in priority order: globals, IN, OUT.
    always_comb begin
        req_all = {out_req, in_req, glb_req};
        en_all  = {out_en,  in_en,  glb_en};
        act_all = req_all & en_all;
    end

    irq_prio_enc #(.N(NUM_SRC), .VEC_W(VEC_W)) u_prio (
        .act_i(act_all), .any_o(irq), .vec_o(vec)
    );

    // Read mux for the software register port.
    always_comb begin
        case (rd_addr)
            RA_GLB_REQ: rd_data = DATA_W'(glb_req);
            RA_GLB_EN:  rd_data = DATA_W'(glb_en);
            RA_IN_REQ:  rd_data = DATA_W'(in_req);
            RA_IN_EN:   rd_data = DATA_W'(in_en);
            RA_OUT_REQ: rd_data = DATA_W'(out_req);
            RA_OUT_EN:  rd_data = DATA_W'(out_en);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/usb_irq_vectorizer_chk.sv
// Module: usb_irq_vectorizer_chk
// Temporal checks for the interrupt controller, bound onto the top module.
module usb_irq_vectorizer_chk #(
    parameter int NG = 5,
    parameter int NE = 8,
    parameter int NS = 21
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [7:0]    wr_data,
    input logic [NG-1:0] glob_evt,
    input logic [NE-1:0] in_busy,
    input logic [NG-1:0] glb_req,
    input logic [NE-1:0] in_req,
    input logic [NS-1:0] req_all,
    input logic [NS-1:0] en_all,
    input logic          irq,
    input logic [7:0]    vec
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (req_all == '0 && en_all == '0)); // R1
    AST_GLB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_evt != '0) |=> ((glb_req & $past(glob_evt)) == $past(glob_evt))); // R2
    AST_IN_FALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(in_busy) & ~in_busy) != '0) |=> ((in_req & $past($past(in_busy) & ~in_busy)) != '0)); // R3
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> ((glb_req & $past(wr_data[NG-1:0] & ~glob_evt)) == '0)); // R4
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0 && (glob_evt & wr_data[NG-1:0]) != '0)
        |=> ((glb_req & $past(glob_evt & wr_data[NG-1:0])) != '0)); // R9
    AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |-> !irq); // R6
    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        vec[1:0] == 2'b00); // R7
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (vec == '0)); // R8
endmodule

bind usb_irq_vectorizer usb_irq_vectorizer_chk #(.NG(5), .NE(8), .NS(21)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .glob_evt(glob_evt), .in_busy(in_busy),
    .glb_req(glb_req), .in_req(in_req), .req_all(req_all),
    .en_all(en_all), .irq(irq), .vec(vec)
);

// File: tb/usb_irq_vectorizer_tb.sv
module usb_irq_vectorizer_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic [4:0] glob_evt = 0;
    logic [7:0] in_busy = 0;
    logic [7:0] out_busy = 0;
    logic       irq;
    logic [7:0] vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    usb_irq_vectorizer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .glob_evt(glob_evt), .in_busy(in_busy), .out_busy(out_busy),
        .irq(irq), .vec(vec)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Register address holding a source's request bit, and its bit number.
    function automatic int src_addr(input int s);
        return (s < 5) ? 0 : (s < 13) ? 2 : 4;
    endfunction
    function automatic int src_bit(input int s);
        return (s < 5) ? s : (s < 13) ? s - 5 : s - 13;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = 3'(a);
        #1;
        d = rd_data;
    endtask

    // Fire one source; returns at the negedge after it has latched.
    task automatic fire(input int s);
        int b = src_bit(s);
        @(negedge clk);
        if (s < 5) begin
            glob_evt[b] = 1;
            @(negedge clk);
            glob_evt = 0;
        end else begin
            if (s < 13) in_busy[b] = 1; else out_busy[b] = 1;
            @(negedge clk);
            if (s < 13) in_busy[b] = 0; else out_busy[b] = 0;
            @(negedge clk);
        end
    endtask

    task automatic clr_src(input int s);
        wr(src_addr(s), 1 << src_bit(s));
    endtask

    task automatic enable_all(input bit on);
        wr(1, on ? 8'h1F : 0);
        wr(3, on ? 8'hFF : 0);
        wr(5, on ? 8'hFF : 0);
    endtask

    task automatic clear_all();
        wr(0, 8'h1F); wr(2, 8'hFF); wr(4, 8'hFF);
    endtask

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq", irq, 0);
        check("R1 vec", vec, 0);
        for (int a = 0; a < 6; a++) begin
            rd(a, d); check("R1 reg", d, 0);
        end
        // R5: enable registers round-trip, unused address reads zero
        wr(1, 8'h0A); rd(1, d); check("R5 glb_en", d, 8'h0A);
        wr(3, 8'hA5); rd(3, d); check("R5 in_en", d, 8'hA5);
        wr(5, 8'h3C); rd(5, d); check("R5 out_en", d, 8'h3C);
        rd(7, d); check("R5 unused", d, 0);
        // R6: pending but disabled source raises no irq
        enable_all(0);
        fire(0);
        check("R6 disabled irq", irq, 0);
        rd(0, d); check("R6 still pending", d, 1);
        clear_all();
        enable_all(1);
        // R2 R3 R7 R4 R8: each source alone
        for (int s = 0; s < 21; s++) begin
            fire(s);
            rd(src_addr(s), d);
            check(s < 5 ? "R2 latch" : "R3 latch", d, 1 << src_bit(s));
            check("R6 irq", irq, 1);
            check("R7 vec", vec, 4 * s);
            clr_src(s);
            rd(src_addr(s), d);
            check("R4 cleared", d, 0);
            check("R8 idle vec", vec, 0);
            check("R8 idle irq", irq, 0);
        end
        // R3: rising busy edge sets nothing
        @(negedge clk); in_busy = 8'hFF; out_busy = 8'hFF;
        @(negedge clk); @(negedge clk);
        check("R3 rise", irq, 0);
        // R3: R9 busy fall during clear of same bit keeps it set
        @(negedge clk);
        in_busy = 8'hFE; wr_en = 1; wr_addr = 2; wr_data = 8'h01;
        @(negedge clk); wr_en = 0;
        rd(2, d); check("R9 ep collision", d, 1);
        @(negedge clk); in_busy = 0; out_busy = 0;
        @(negedge clk);
        clear_all();
        // R7: every pair, lowest index wins; clearing it exposes the other
        for (int i = 0; i < 21; i++) begin
            for (int j = i + 1; j < 21; j++) begin
                fire(j); fire(i);
                check("R7 pair", vec, 4 * i);
                clr_src(i);
                check("R8 after clear", vec, 4 * j);
                clr_src(j);
            end
        end
        // R6 R7: all pending, only one enabled at a time
        for (int s = 0; s < 21; s++) fire(s);
        enable_all(0);
        for (int s = 0; s < 21; s++) begin
            wr(src_addr(s) + 1, 1 << src_bit(s));
            check("R6 single en irq", irq, 1);
            check("R7 single en vec", vec, 4 * s);
            wr(src_addr(s) + 1, 0);
        end
        // R4: writing zeros clears nothing
        wr(0, 0); rd(0, d); check("R4 zero write", d, 8'h1F);
        wr(0, 8'h05); rd(0, d); check("R4 partial", d, 8'h1A);
        clear_all();
        enable_all(1);
        // R9: global event and clear on the same edge
        @(negedge clk);
        glob_evt = 5'b00010; wr_en = 1; wr_addr = 0; wr_data = 8'h02;
        @(negedge clk);
        glob_evt = 0; wr_en = 0;
        rd(0, d); check("R9 glb collision", d, 2);
        check("R9 vec", vec, 4);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule